// File: doc/BRIEF.md
# Configurable SPI Master Transfer Engine

This block is the master side of a serial peripheral link. It makes the serial clock from the system clock through a power-of-two divider and supports all four clock polarity and phase combinations. It shifts 8-bit or 16-bit frames with either bit order. It transfers data over one of three line arrangements: full-duplex on separate out and in lines, receive-only with the clock free-running, or a single shared data line whose direction is set by an output-enable bit.

Software-style configuration is presented on parallel inputs and latched by a write strobe. The strobe is accepted only while the engine is idle. Transmit words enter through a one-word holding buffer. Received words come back on a data bus with a one-cycle valid strobe. An active-low slave select can be driven for the whole duration of activity, and it covers back-to-back frames.

Top module: `spi_xfer_top`

## Requirements
- R1: The serial clock toggles once every 2^cfg_div system clock cycles while a transfer runs, so its period is 2^(cfg_div+1) cycles (2 up to 256).
- R2: While no transfer runs, sck rests at cfg_cpol. A configuration write is accepted only when busy is low. A write made while busy has no effect.
- R3: With cfg_cpha=0, data is sampled on the first (leading) edge of each bit and changed on the trailing edge. With cfg_cpha=1, data is changed on the leading edge and sampled on the trailing edge. The first bit of a frame is on the line before the first edge.
- R4: cfg_lsb_first=1 sends and receives bit 0 first. cfg_lsb_first=0 sends and receives the top bit of the frame first.
- R5: cfg_wide=1 selects 16-bit frames. cfg_wide=0 selects 8-bit frames, which use tx_data[7:0] and return the received byte in rx_data[7:0] with rx_data[15:8] zero.
- R6: A configuration write with both cfg_rx_only=1 and cfg_bidir=1 is rejected, and the previous configuration stays in force.
- R7: With cfg_bidir=1, cfg_bidir_out=1 makes the engine drive mosi_o (mosi_oe=1) and raise no rx_valid. cfg_bidir_out=0 releases the line (mosi_oe=0) and receives from mosi_i. In full-duplex mode mosi_oe=1 and data is received from miso_i. In receive-only mode mosi_oe=0.
- R8: In full-duplex or bidirectional-transmit mode, a frame starts only when enable is high and the transmit buffer holds a word. A word written while enable is low waits in the buffer.
- R9: In receive-only mode, and in bidirectional mode with cfg_bidir_out=0, frames start as soon as enable is high and run back to back. They stop at the end of the frame during which enable goes low.
- R10: busy is high from the start of the first frame until after the last edge of the final frame. rx_valid pulses for one cycle after the last edge of each receiving frame. tx_empty rises when the buffered word moves into the shifter. tx_wr is ignored while tx_empty is low.
- R11: With cfg_sel_oe=1, ss_n is low whenever busy is high, including across back-to-back frames. It is high otherwise and whenever cfg_sel_oe=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Engine enable level |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_div | input | 3 | Clock divider exponent |
| cfg_cpol | input | 1 | Idle level of sck |
| cfg_cpha | input | 1 | Sampling edge select |
| cfg_lsb_first | input | 1 | Bit order select |
| cfg_wide | input | 1 | 16-bit frame select |
| cfg_rx_only | input | 1 | Receive-only simplex select |
| cfg_bidir | input | 1 | Single shared data line select |
| cfg_bidir_out | input | 1 | Shared line direction, 1 = transmit |
| cfg_sel_oe | input | 1 | Slave select output enable |
| tx_wr | input | 1 | Transmit buffer write strobe |
| tx_data | input | 16 | Transmit word |
| tx_empty | output | 1 | Transmit buffer free |
| rx_valid | output | 1 | Received word strobe |
| rx_data | output | 16 | Received word |
| busy | output | 1 | Transfer in progress |
| sck | output | 1 | Serial clock |
| mosi_o | output | 1 | Outgoing data line value |
| mosi_oe | output | 1 | Outgoing data line drive enable |
| mosi_i | input | 1 | Shared line input in bidirectional receive |
| miso_i | input | 1 | Incoming data line |
| ss_n | output | 1 | Active-low slave select |

## Verification
The assertions assume that configuration writes are made only when no frame is starting in the same cycle. A frame starts in the same cycle when enable is high with a word buffered, or enable is high in a receive mode. The bench therefore writes configuration only while enable is low or while no transmit word is pending and the mode transmits. The assertions also assume that enable is not raised in a receive mode until the configuration is final. The bench keeps miso_i and mosi_i changing only on the falling system clock, one cycle after the sampling edge it sees. This keeps the data seen by the engine stable at every sampling edge.

// File: rtl/spi_xfer_pkg.sv
// Shared types for the SPI master transfer engine.
// Assumes nothing beyond a 3-bit divider field and single-bit mode controls.
package spi_xfer_pkg;

    // Latched configuration word.
    typedef struct packed {
        logic [2:0] div;
        logic       cpol;
        logic       cpha;
        logic       lsb_first;
        logic       wide;
        logic       rx_only;
        logic       bidir;
        logic       bidir_out;
        logic       sel_oe;
    } spi_cfg_t;

    // Shifter sequencing states.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } spi_state_e;

endpackage

// File: rtl/spi_cfg_reg.sv
// Configuration register. It latches a new setting on a write strobe only
// while the engine is idle. A setting that asks for receive-only and the
// shared-line mode at once is dropped. Assumes busy comes from the shifter.
module spi_cfg_reg
    import spi_xfer_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr,
    input  logic     busy,
    input  spi_cfg_t cfg_in,
    output spi_cfg_t cfg_q
);

    logic legal;
    logic accept;

    // Legal when the two exclusive line modes are not both requested.
    always_comb begin
        legal  = !(cfg_in.rx_only && cfg_in.bidir);
        accept = wr && !busy && legal;
    end

    // Hold configuration, update on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (accept) begin
            cfg_q <= cfg_in;
        end
    end

endmodule

// File: rtl/spi_clkgen.sv
// Half-period tick generator. While run is high it emits a one-cycle tick
// every 2^div system cycles. The count restarts whenever run is low.
// Assumes div is stable while run is high.
module spi_clkgen #(
    parameter int DIVW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] div,
    output logic            tick
);

    localparam int CW = 2 ** DIVW;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;

    // Terminal count for the selected half period.
    always_comb begin
        lim  = (CW'(1) << div) - CW'(1);
        tick = run && (cnt_q == lim);
    end

    // Count system cycles within a half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/spi_shifter.sv
// Frame sequencer and shift registers. It counts sck edges per frame and
// picks the sampling and changing edges from the phase bit. It also
// assembles received words and decides whether to chain another frame.
// Assumes cfg is stable while busy and that tick comes from spi_clkgen.
module spi_shifter
    import spi_xfer_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  spi_cfg_t      cfg,
    input  logic          enable,
    input  logic          tick,
    input  logic          tx_full,
    input  logic [DW-1:0] tx_buf,
    input  logic          miso_i,
    input  logic          mosi_i,
    output logic          run,
    output logic          load,
    output logic          sck,
    output logic          mosi_o,
    output logic          mosi_oe,
    output logic          rx_valid,
    output logic [DW-1:0] rx_data
);

    localparam int HW = DW / 2;
    localparam int EW = $clog2(2 * DW);

    spi_state_e    state_q;
    logic [EW-1:0] edge_q;
    logic [EW-1:0] last_edge;
    logic          sck_lvl_q;
    logic [DW-1:0] tx_sr_q;
    logic [DW-1:0] rx_sr_q;
    logic          rx_mode;
    logic          rx_capture;
    logic          start_ok;
    logic          frame_end;
    logic          sample_now;
    logic          shift_now;
    logic          in_bit;
    logic [DW-1:0] rx_shift;
    logic [DW-1:0] rx_next;
    logic [DW-1:0] rx_word;
    logic [DW-1:0] tx_shifted;

    // Mode decode, edge roles and start rule.
    always_comb begin
        rx_mode    = cfg.rx_only || (cfg.bidir && !cfg.bidir_out);
        rx_capture = !(cfg.bidir && cfg.bidir_out);
        start_ok   = enable && (rx_mode || tx_full);
        run        = (state_q == ST_XFER);
        last_edge  = cfg.wide ? EW'(2 * DW - 1) : EW'(DW - 1);
        frame_end  = run && tick && (edge_q == last_edge);
        sample_now = run && tick && (edge_q[0] == cfg.cpha);
        shift_now  = run && tick && (edge_q[0] != cfg.cpha)
                     && (edge_q != last_edge)
                     && !(cfg.cpha && (edge_q == '0));
        load       = start_ok && !rx_mode && ((state_q == ST_IDLE) || frame_end);
    end

    // Receive path: pick the input line and shift toward the frame end.
    always_comb begin
        in_bit   = cfg.bidir ? mosi_i : miso_i;
        rx_shift = cfg.lsb_first ? {in_bit, rx_sr_q[DW-1:1]}
                                 : {rx_sr_q[DW-2:0], in_bit};
        rx_next  = sample_now ? rx_shift : rx_sr_q;
        if (cfg.wide) begin
            rx_word = rx_next;
        end else if (cfg.lsb_first) begin
            rx_word = {{HW{1'b0}}, rx_next[DW-1:HW]};
        end else begin
            rx_word = {{HW{1'b0}}, rx_next[HW-1:0]};
        end
    end

    // Transmit path: current bit and next shifter contents.
    always_comb begin
        tx_shifted = cfg.lsb_first ? (tx_sr_q >> 1) : (tx_sr_q << 1);
        if (cfg.lsb_first) begin
            mosi_o = tx_sr_q[0];
        end else begin
            mosi_o = cfg.wide ? tx_sr_q[DW-1] : tx_sr_q[HW-1];
        end
        mosi_oe = !rx_mode;
        sck     = cfg.cpol ^ sck_lvl_q;
    end

    // Frame sequencing, edge counting and shift register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            edge_q    <= '0;
            sck_lvl_q <= 1'b0;
            tx_sr_q   <= '0;
            rx_sr_q   <= '0;
            rx_valid  <= 1'b0;
            rx_data   <= '0;
        end else begin
            rx_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_ok) begin
                        state_q   <= ST_XFER;
                        edge_q    <= '0;
                        sck_lvl_q <= 1'b0;
                        tx_sr_q   <= rx_mode ? '0 : tx_buf;
                        rx_sr_q   <= '0;
                    end
                end
                ST_XFER: begin
                    if (tick) begin
                        sck_lvl_q <= ~sck_lvl_q;
                        if (sample_now) rx_sr_q <= rx_shift;
                        if (shift_now)  tx_sr_q <= tx_shifted;
                        if (frame_end) begin
                            rx_valid <= rx_capture;
                            rx_data  <= rx_word;
                            edge_q   <= '0;
                            rx_sr_q  <= '0;
                            if (start_ok) begin
                                tx_sr_q <= rx_mode ? '0 : tx_buf;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end else begin
                            edge_q <= edge_q + EW'(1);
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spi_xfer_top.sv
// Top of the SPI master transfer engine. It joins the configuration
// register, the half-period tick generator and the shifter. It holds the
// one-word transmit buffer and drives the slave select.
// Assumes configuration writes are not made in a cycle that starts a frame.
module spi_xfer_top
    import spi_xfer_pkg::*;
#(
    parameter int DW   = 16,
    parameter int DIVW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            cfg_we,
    input  logic [DIVW-1:0] cfg_div,
    input  logic            cfg_cpol,
    input  logic            cfg_cpha,
    input  logic            cfg_lsb_first,
    input  logic            cfg_wide,
    input  logic            cfg_rx_only,
    input  logic            cfg_bidir,
    input  logic            cfg_bidir_out,
    input  logic            cfg_sel_oe,
    input  logic            tx_wr,
    input  logic [DW-1:0]   tx_data,
    output logic            tx_empty,
    output logic            rx_valid,
    output logic [DW-1:0]   rx_data,
    output logic            busy,
    output logic            sck,
    output logic            mosi_o,
    output logic            mosi_oe,
    input  logic            mosi_i,
    input  logic            miso_i,
    output logic            ss_n
);

    spi_cfg_t      cfg_in;
    spi_cfg_t      cfg_q;
    logic          tick;
    logic          run;
    logic          load;
    logic          tx_full_q;
    logic [DW-1:0] tx_buf_q;

    // Gather configuration inputs into one word.
    always_comb begin
        cfg_in.div       = cfg_div;
        cfg_in.cpol      = cfg_cpol;
        cfg_in.cpha      = cfg_cpha;
        cfg_in.lsb_first = cfg_lsb_first;
        cfg_in.wide      = cfg_wide;
        cfg_in.rx_only   = cfg_rx_only;
        cfg_in.bidir     = cfg_bidir;
        cfg_in.bidir_out = cfg_bidir_out;
        cfg_in.sel_oe    = cfg_sel_oe;
    end

    spi_cfg_reg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cfg_we),
        .busy   (run),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    spi_clkgen #(.DIVW(DIVW)) u_clk (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (cfg_q.div),
        .tick  (tick)
    );

    spi_shifter #(.DW(DW)) u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg      (cfg_q),
        .enable   (enable),
        .tick     (tick),
        .tx_full  (tx_full_q),
        .tx_buf   (tx_buf_q),
        .miso_i   (miso_i),
        .mosi_i   (mosi_i),
        .run      (run),
        .load     (load),
        .sck      (sck),
        .mosi_o   (mosi_o),
        .mosi_oe  (mosi_oe),
        .rx_valid (rx_valid),
        .rx_data  (rx_data)
    );

    // One-word transmit buffer: fill when free, drain when the shifter loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_full_q <= 1'b0;
            tx_buf_q  <= '0;
        end else if (load) begin
            tx_full_q <= 1'b0;
        end else if (tx_wr && !tx_full_q) begin
            tx_full_q <= 1'b1;
            tx_buf_q  <= tx_data;
        end
    end

    // Status and select outputs.
    always_comb begin
        busy     = run;
        tx_empty = !tx_full_q;
        ss_n     = !(cfg_q.sel_oe && run);
    end

endmodule

// File: rtl/spi_xfer_chk.sv
// Property checker for spi_xfer_top, attached by bind. It watches the
// outputs and the latched configuration. Assumes the synchronous reset.
module spi_xfer_chk
    import spi_xfer_pkg::*;
(
    input logic     clk,
    input logic     rst_n,
    input logic     busy,
    input logic     sck,
    input logic     ss_n,
    input logic     mosi_oe,
    input logic     rx_valid,
    input spi_cfg_t cfg_q
);

    // Idle clock level follows polarity.
    assert_sck_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sck == cfg_q.cpol));

    // Configuration frozen while a transfer runs.
    assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cfg_q));

    // The two exclusive line modes never coexist.
    assert_mode_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_q.rx_only && cfg_q.bidir));

    // Receiving modes release the outgoing line.
    assert_line_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.rx_only || (cfg_q.bidir && !cfg_q.bidir_out)) |-> !mosi_oe);

    // A received word only follows transfer activity.
    assert_rx_after_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(busy));

    // Select held low throughout activity when enabled.
    assert_sel_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_q.sel_oe) |-> !ss_n);

    // Select stays high with no activity.
    assert_sel_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ss_n);

endmodule

bind spi_xfer_top spi_xfer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .sck      (sck),
    .ss_n     (ss_n),
    .mosi_oe  (mosi_oe),
    .rx_valid (rx_valid),
    .cfg_q    (cfg_q)
);

// File: tb/spi_xfer_top_tb_top.sv
`timescale 1ns/1ps
module spi_xfer_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_div = '0;
    logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0, cfg_wide = 1'b0;
    logic        cfg_rx_only = 1'b0, cfg_bidir = 1'b0, cfg_bidir_out = 1'b0, cfg_sel_oe = 1'b0;
    logic        tx_wr = 1'b0;
    logic [15:0] tx_data = '0;
    logic        tx_empty, rx_valid, busy, sck, mosi_o, mosi_oe, ss_n;
    logic [15:0] rx_data;
    logic        mosi_i, miso_i;

    int n_tests = 0;
    int n_fail  = 0;

    // Effective configuration as the bench expects the engine to hold it.
    logic [2:0]  e_div = '0;
    logic        e_cpol = 1'b0, e_cpha = 1'b0, e_lsb = 1'b0, e_wide = 1'b0, e_sel = 1'b0;
    logic [15:0] pat_b = '0;

    // Monitor state.
    logic        mon_clr = 1'b0;
    int          mon_k = 0;
    int          cyc = 0;
    logic        have_edge = 1'b0;
    logic        prev_sck = 1'b0;
    int          gap_bad = 0;
    int          ss_bad = 0;
    int          rx_cnt = 0;
    logic [15:0] cap_w [0:7];
    logic [15:0] rx_got [0:7];

    always #2 clk = ~clk;

    spi_xfer_top dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
        .cfg_div(cfg_div), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_lsb_first(cfg_lsb_first), .cfg_wide(cfg_wide),
        .cfg_rx_only(cfg_rx_only), .cfg_bidir(cfg_bidir),
        .cfg_bidir_out(cfg_bidir_out), .cfg_sel_oe(cfg_sel_oe),
        .tx_wr(tx_wr), .tx_data(tx_data), .tx_empty(tx_empty),
        .rx_valid(rx_valid), .rx_data(rx_data), .busy(busy), .sck(sck),
        .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i),
        .miso_i(miso_i), .ss_n(ss_n)
    );

    function automatic int fbits(input logic wide);
        return wide ? 16 : 8;
    endfunction

    function automatic int bitpos(input int k, input logic lsb, input logic wide);
        int n = fbits(wide);
        int idx = k % n;
        return lsb ? idx : (n - 1 - idx);
    endfunction

    function automatic logic [15:0] mask_w(input logic [15:0] w, input logic wide);
        return wide ? w : {8'h00, w[7:0]};
    endfunction

    // Slave model: present the pattern bit for the next sample.
    assign miso_i = pat_b[bitpos(mon_k, e_lsb, e_wide)];
    assign mosi_i = miso_i;

    // Observe the bus on the falling clock edge.
    always @(negedge clk) begin
        if (mon_clr) begin
            mon_k = 0; cyc = 0; have_edge = 1'b0; gap_bad = 0; ss_bad = 0; rx_cnt = 0;
            for (int i = 0; i < 8; i++) begin cap_w[i] = '0; rx_got[i] = '0; end
            prev_sck = sck;
        end else begin
            cyc = cyc + 1;
            if (sck != prev_sck) begin
                if (have_edge && cyc != (1 << e_div)) gap_bad = gap_bad + 1;
                have_edge = 1'b1;
                cyc = 0;
                if (((prev_sck == e_cpol) ? 1'b1 : 1'b0) != e_cpha) begin
                    if (mon_k / fbits(e_wide) < 8)
                        cap_w[mon_k / fbits(e_wide)][bitpos(mon_k, e_lsb, e_wide)] = mosi_o;
                    mon_k = mon_k + 1;
                end
            end
            prev_sck = sck;
            if (!busy) have_edge = 1'b0;
            if (busy && e_sel && ss_n) ss_bad = ss_bad + 1;
            if (!busy && !ss_n) ss_bad = ss_bad + 1;
            if (rx_valid) begin
                if (rx_cnt < 8) rx_got[rx_cnt] = rx_data;
                rx_cnt = rx_cnt + 1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clr_mon();
        @(negedge clk); mon_clr = 1'b1;
        @(negedge clk); @(negedge clk); mon_clr = 1'b0;
    endtask

    task automatic set_cfg(input logic [2:0] d, input logic cp, input logic ph,
                           input logic l, input logic w, input logic ro,
                           input logic bd, input logic bo, input logic so);
        @(negedge clk);
        cfg_div = d; cfg_cpol = cp; cfg_cpha = ph; cfg_lsb_first = l; cfg_wide = w;
        cfg_rx_only = ro; cfg_bidir = bd; cfg_bidir_out = bo; cfg_sel_oe = so;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        if (!(ro && bd) && !busy) begin
            e_div = d; e_cpol = cp; e_cpha = ph; e_lsb = l; e_wide = w; e_sel = so;
        end
    endtask

    task automatic wait_busy(input logic lvl);
        int t = 0;
        while (busy !== lvl && t < 20000) begin @(negedge clk); t++; end
    endtask

    task automatic write_tx(input logic [15:0] d);
        @(negedge clk); tx_data = d; tx_wr = 1'b1;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    // One full-duplex frame with its checks.
    task automatic one_frame(input logic [15:0] d, input logic [15:0] p, input string tag);
        pat_b = p;
        clr_mon();
        write_tx(d);
        wait_busy(1'b1);
        chk({tag, " R10 tx_empty at start"}, tx_empty, 1'b1);
        wait_busy(1'b0);
        @(negedge clk); @(negedge clk);
        chk({tag, " R3 R4 R5 mosi word"}, cap_w[0], mask_w(d, e_wide));
        chk({tag, " R3 R4 R5 rx word"}, rx_got[0], mask_w(p, e_wide));
        chk({tag, " R10 rx_valid count"}, rx_cnt, 1);
        chk({tag, " R1 half period"}, gap_bad, 0);
        chk({tag, " R11 select"}, ss_bad, 0);
        chk({tag, " R2 idle level"}, sck, e_cpol);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state.
        chk("R10 reset busy", busy, 1'b0);
        chk("R10 reset tx_empty", tx_empty, 1'b1);
        chk("R11 reset ss_n", ss_n, 1'b1);
        chk("R2 reset sck", sck, 1'b0);
        chk("R10 reset rx_valid", rx_valid, 1'b0);

        // Directed: mode 0, MSB first, byte.
        set_cfg(3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        enable = 1'b1;
        one_frame(16'h12A5, 16'h773C, "dir0");

        // R8: word waits while disabled.
        enable = 1'b0;
        set_cfg(3'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        pat_b = 16'h0F0F;
        clr_mon();
        write_tx(16'hBEEF);
        repeat (20) @(negedge clk);
        chk("R8 no start while disabled", busy, 1'b0);
        chk("R8 word held", tx_empty, 1'b0);
        enable = 1'b1;
        wait_busy(1'b1);
        wait_busy(1'b0);
        @(negedge clk);
        chk("R8 R4 held word sent", cap_w[0], 16'hBEEF);
        chk("R8 R5 rx word", rx_got[0], 16'h0F0F);

        // R2: write while busy ignored.
        pat_b = 16'h0000;
        clr_mon();
        write_tx(16'h0001);
        wait_busy(1'b1);
        set_cfg(3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        wait_busy(1'b0);
        @(negedge clk);
        chk("R2 busy write ignored sck idle", sck, 1'b1);
        chk("R2 busy write ignored data", cap_w[0], 16'h0001);

        // Directed slowest divider.
        set_cfg(3'd7, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        one_frame(16'h0081, 16'h00C3, "div7");

        // Random frames.
        for (int i = 0; i < 24; i++) begin
            logic [2:0] d; logic cp, ph, l, w;
            d = 3'($urandom_range(0, 3)); cp = 1'($urandom); ph = 1'($urandom);
            l = 1'($urandom); w = 1'($urandom);
            set_cfg(d, cp, ph, l, w, 1'b0, 1'b0, 1'b0, 1'b1);
            one_frame(16'($urandom), 16'($urandom), "rnd");
        end

        // Back to back frames keep select low.
        set_cfg(3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        pat_b = 16'h5AA5;
        clr_mon();
        write_tx(16'h1357);
        wait_busy(1'b1);
        write_tx(16'h2468);
        wait_busy(1'b0);
        @(negedge clk);
        chk("R11 b2b select", ss_bad, 0);
        chk("R10 b2b two words", rx_cnt, 2);
        chk("R10 b2b first", cap_w[0], 16'h1357);
        chk("R10 b2b second", cap_w[1], 16'h2468);
        chk("R1 b2b period", gap_bad, 0);

        // R6: rejected mode pair keeps full-duplex.
        set_cfg(3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        chk("R6 reject keeps duplex oe", mosi_oe, 1'b1);
        chk("R6 reject no start", busy, 1'b0);

        // R7: shared line transmit.
        set_cfg(3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        @(negedge clk);
        chk("R7 bidir out oe", mosi_oe, 1'b1);
        pat_b = 16'hFFFF;
        clr_mon();
        write_tx(16'hC0DE);
        wait_busy(1'b1);
        wait_busy(1'b0);
        @(negedge clk);
        chk("R7 bidir out data", cap_w[0], 16'hC0DE);
        chk("R7 bidir out no rx_valid", rx_cnt, 0);

        // R9/R7: shared line receive free-runs from enable.
        enable = 1'b0;
        set_cfg(3'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        pat_b = 16'h9C31;
        clr_mon();
        @(negedge clk);
        chk("R7 bidir in oe", mosi_oe, 1'b0);
        enable = 1'b1;
        while (rx_cnt < 2) @(negedge clk);
        enable = 1'b0;
        wait_busy(1'b0);
        @(negedge clk);
        chk("R9 R7 bidir rx word0", rx_got[0], 16'h9C31);
        chk("R9 R7 bidir rx word1", rx_got[1], 16'h9C31);
        chk("R10 bidir rx tx_empty", tx_empty, 1'b1);

        // R9: receive-only free-run without any transmit word.
        set_cfg(3'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        pat_b = 16'h00B6;
        clr_mon();
        chk("R7 rx only oe", mosi_oe, 1'b0);
        enable = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R9 starts on enable", busy, 1'b1);
        while (rx_cnt < 3) @(negedge clk);
        enable = 1'b0;
        wait_busy(1'b0);
        @(negedge clk);
        chk("R9 frames back to back", (rx_cnt >= 3) ? 1 : 0, 1);
        chk("R9 rx0", rx_got[0], 16'h00B6);
        chk("R9 rx2", rx_got[2], 16'h00B6);
        chk("R11 rx only select", ss_bad, 0);
        chk("R1 rx only period", gap_bad, 0);
        repeat (10) @(negedge clk);
        chk("R9 stops after disable", busy, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        #(4 * 190000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule